// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs its count on a slow clock of its own. The counter keeps running if the fast system clock stops. Software reaches the block only through a 16-bit key register plus a prescaler register, a reload register and a status register, all on a simple single-cycle bus in the fast clock domain. Magic key values start the watchdog, refresh its counter and open the two configuration registers for writing. Once it has started, nothing but a system reset stops it or drops its request for the slow clock.

Configuration writes are held on the bus side. Each one is handed to the slow domain through a toggle handshake. A per-register busy flag stays set until the slow side acknowledges the write. A refresh takes the same kind of path. A strap input sampled during reset can start the watchdog with no software action. A debug-freeze input pauses counting while the core is halted.

Register addresses: 0 is the key register (reads as 0), 1 is the prescaler, 2 is the reload value and 3 is the status register.

Top module: `kwdt_top`

## Requirements
- R1: The 12-bit down-counter sits at 0xFFF until the watchdog starts. With the reset prescaler (divide by 4), the first reset pulse comes 4096 x 4 slow-clock cycles after start, give or take a few cycles of synchronizer latency.
- R2: Writing 0xAAAA to address 0 while the watchdog runs loads the reload value into the counter. The next reset pulse then comes (reload + 1) x divide slow cycles after the refresh lands. Refreshing more often than that produces no pulse.
- R3: `wdt_reset_o` is a pulse exactly one slow cycle wide. After each pulse the counter reloads and keeps counting, so with no refresh the pulses repeat every (reload + 1) x divide slow cycles.
- R4: Writes to the prescaler (address 1, bits 2:0) and the reload register (address 2, bits 11:0) take effect only after 0x5555 has been written to address 0. Otherwise they are ignored. Reads return the accepted values, with reset values 0 and 0xFFF. Address 0 reads as 0.
- R5: Any key value other than 0xAAAA, 0x5555 and 0xCCCC locks the configuration registers again and has no other effect.
- R6: Writing 0xCCCC to address 0 raises `slow_clk_req_o` and enables counting. No later key write clears either one. Before start the counter does not run, no pulse is produced, and refresh keys are ignored.
- R7: When `hw_start_i` is high during reset, the watchdog comes out of reset already started, with `slow_clk_req_o` high.
- R8: Prescaler codes 0 to 6 divide the slow clock by 4, 8, 16, 32, 64, 128 and 256. Code 7 also divides by 256.
- R9: Status bit 0 is the prescaler busy flag and bit 1 is the reload busy flag. A flag rises the cycle after its register accepts a write and clears only after the slow domain acknowledges. A write to a register whose busy flag is set is ignored.
- R10: While `dbg_freeze_i` is high, the counter and the prescaler hold their values. When it drops, counting resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Slow independent counting clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| hw_start_i | input | 1 | Hardware start strap, sampled during reset |
| dbg_freeze_i | input | 1 | High pauses the counter while the core is halted |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data for the previous cycle's address |
| slow_clk_req_o | output | 1 | Request to keep the slow oscillator running |
| wdt_reset_o | output | 1 | One-slow-cycle reset request pulse |

## Verification
The properties assume that the slow clock is several times slower than the bus clock and that every divide is at least 4, so two reset pulses can never fall on adjacent slow cycles. They also assume that `dbg_freeze_i` changes rarely compared with the slow clock. The stimulus drives single-cycle writes at the bus clock's falling edge and runs the slow clock at an unrelated 34 ns period. It holds freeze for hundreds of slow cycles and spaces refreshes well apart from each other. The timing checks accept a window of a few slow cycles, which covers the synchronizer latency on the request path.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  typedef enum logic [1:0] {
    A_KEY    = 2'd0,
    A_PRESC  = 2'd1,
    A_RELOAD = 2'd2,
    A_STATUS = 2'd3
  } kwdt_addr_e;

  // handshake channel indices
  localparam int CH_PR = 0;
  localparam int CH_RL = 1;
  localparam int CH_RF = 2;
  localparam int N_CH  = 3;
endpackage

// File: rtl/kwdt_sync.sv
`timescale 1ns/1ps
module kwdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/kwdt_cdc_rx.sv
`timescale 1ns/1ps
module kwdt_cdc_rx #(
  parameter int NCH    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_tgl,
  output logic [NCH-1:0] ev,
  output logic [NCH-1:0] ack_tgl
);
  logic [NCH-1:0] req_s;
  logic [NCH-1:0] req_d;

  kwdt_sync #(.W(NCH), .STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_tgl), .q(req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) req_d <= '0;
    else     req_d <= req_s;
  end

  // a change of the synchronized toggle is one event; the delayed copy
  // doubles as the acknowledge returned to the bus side
  assign ev      = req_s ^ req_d;
  assign ack_tgl = req_d;
endmodule

// File: rtl/kwdt_bus_regs.sv
`timescale 1ns/1ps
module kwdt_bus_regs
  import kwdt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PR_W   = 3,
  parameter int DATA_W = 16,
  parameter int NCH    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_start,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    ack_b,
  output logic [DATA_W-1:0] rdata,
  output logic              started,
  output logic              unlocked,
  output logic [PR_W-1:0]   pr_sh,
  output logic [CNT_W-1:0]  rl_sh,
  output logic [NCH-1:0]    req_tgl,
  output logic [NCH-1:0]    busy
);
  logic [DATA_W-1:0] rd_mux;
  logic [KEY_W-1:0]  key;

  assign key  = wdata[KEY_W-1:0];
  assign busy = req_tgl ^ ack_b;

  always_comb begin
    rd_mux = '0;
    case (kwdt_addr_e'(addr))
      A_PRESC:  rd_mux[PR_W-1:0]  = pr_sh;
      A_RELOAD: rd_mux[CNT_W-1:0] = rl_sh;
      A_STATUS: rd_mux[1:0]       = {busy[CH_RL], busy[CH_PR]};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started  <= hw_start;
      unlocked <= 1'b0;
      pr_sh    <= '0;
      rl_sh    <= '1;
      req_tgl  <= '0;
      rdata    <= '0;
    end else begin
      rdata <= rd_mux;
      if (wr_en) begin
        case (kwdt_addr_e'(addr))
          A_KEY: begin
            if (key == KEY_REFRESH) begin
              if (started && !busy[CH_RF]) req_tgl[CH_RF] <= ~req_tgl[CH_RF];
            end else if (key == KEY_UNLOCK) begin
              unlocked <= 1'b1;
            end else if (key == KEY_START) begin
              started <= 1'b1;
            end else begin
              unlocked <= 1'b0;
            end
          end
          A_PRESC: begin
            if (unlocked && !busy[CH_PR]) begin
              pr_sh          <= wdata[PR_W-1:0];
              req_tgl[CH_PR] <= ~req_tgl[CH_PR];
            end
          end
          A_RELOAD: begin
            if (unlocked && !busy[CH_RL]) begin
              rl_sh          <= wdata[CNT_W-1:0];
              req_tgl[CH_RL] <= ~req_tgl[CH_RL];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/kwdt_core.sv
`timescale 1ns/1ps
module kwdt_core #(
  parameter int CNT_W    = 12,
  parameter int PR_W     = 3,
  parameter int MIN_LOG  = 2,
  parameter int MAX_CODE = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             frz,
  input  logic             ev_pr,
  input  logic             ev_rl,
  input  logic             ev_rf,
  input  logic [PR_W-1:0]  pr_in,
  input  logic [CNT_W-1:0] rl_in,
  output logic             wdt_rst,
  output logic [CNT_W-1:0] cnt
);
  localparam int DIVC_W = MIN_LOG + MAX_CODE;

  logic [PR_W-1:0]   pr_s;
  logic [PR_W-1:0]   code_c;
  logic [CNT_W-1:0]  rl_s;
  logic [DIVC_W-1:0] div_cnt;
  logic [DIVC_W-1:0] div_last;

  // codes above the top one saturate at the slowest divide
  always_comb begin
    code_c   = (pr_s > PR_W'(MAX_CODE)) ? PR_W'(MAX_CODE) : pr_s;
    div_last = DIVC_W'((1 << (int'(code_c) + MIN_LOG)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_s    <= '0;
      rl_s    <= '1;
      div_cnt <= '0;
      cnt     <= '1;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= 1'b0;
      if (ev_pr) pr_s <= pr_in;
      if (ev_rl) rl_s <= rl_in;
      if (run && ev_rf) begin
        cnt     <= rl_s;
        div_cnt <= '0;
      end else if (run && !frz) begin
        if (div_cnt >= div_last) begin
          div_cnt <= '0;
          if (cnt == '0) begin
            wdt_rst <= 1'b1;
            cnt     <= rl_s;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int PR_W         = 3,
  parameter int DATA_W       = 16,
  parameter int DIV_MIN_LOG  = 2,
  parameter int DIV_MAX_CODE = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              slow_rst,
  input  logic              hw_start_i,
  input  logic              dbg_freeze_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              slow_clk_req_o,
  output logic              wdt_reset_o
);
  logic             started;
  logic             unlocked;
  logic [PR_W-1:0]  pr_sh;
  logic [CNT_W-1:0] rl_sh;
  logic [CNT_W-1:0] cnt;
  logic [N_CH-1:0]  req_tgl;
  logic [N_CH-1:0]  ack_tgl;
  logic [N_CH-1:0]  ack_b;
  logic [N_CH-1:0]  busy;
  logic [N_CH-1:0]  ev;
  logic             run_s;
  logic             frz_s;

  kwdt_bus_regs #(.CNT_W(CNT_W), .PR_W(PR_W), .DATA_W(DATA_W), .NCH(N_CH)) u_bus (
    .clk(clk), .rst(rst), .hw_start(hw_start_i), .wr_en(bus_we_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .ack_b(ack_b), .rdata(bus_rdata_o),
    .started(started), .unlocked(unlocked), .pr_sh(pr_sh), .rl_sh(rl_sh),
    .req_tgl(req_tgl), .busy(busy)
  );

  kwdt_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_b)
  );

  kwdt_cdc_rx #(.NCH(N_CH), .STAGES(SYNC_STAGES)) u_rx (
    .clk(slow_clk), .rst(slow_rst), .req_tgl(req_tgl), .ev(ev), .ack_tgl(ack_tgl)
  );

  kwdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk(slow_clk), .rst(slow_rst), .d({dbg_freeze_i, started}), .q({frz_s, run_s})
  );

  kwdt_core #(.CNT_W(CNT_W), .PR_W(PR_W), .MIN_LOG(DIV_MIN_LOG), .MAX_CODE(DIV_MAX_CODE)) u_core (
    .clk(slow_clk), .rst(slow_rst), .run(run_s), .frz(frz_s),
    .ev_pr(ev[CH_PR]), .ev_rl(ev[CH_RL]), .ev_rf(ev[CH_RF]),
    .pr_in(pr_sh), .rl_in(rl_sh), .wdt_rst(wdt_reset_o), .cnt(cnt)
  );

  assign slow_clk_req_o = started;
endmodule

// File: rtl/kwdt_chk.sv
`timescale 1ns/1ps
module kwdt_chk #(
  parameter int CNT_W = 12,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             slow_clk,
  input logic             slow_rst,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic             slow_clk_req_o,
  input logic             wdt_reset_o,
  input logic             unlocked,
  input logic [CNT_W-1:0] rl_sh,
  input logic [NCH-1:0]   busy,
  input logic [NCH-1:0]   ev,
  input logic             run_s,
  input logic             frz_s,
  input logic [CNT_W-1:0] cnt
);
  AST_RESET_PULSE_SINGLE: assert property (@(posedge slow_clk) disable iff (slow_rst)
    wdt_reset_o |=> !wdt_reset_o); // R3

  AST_CLK_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    slow_clk_req_o |=> slow_clk_req_o); // R6

  AST_IDLE_NO_RESET: assert property (@(posedge slow_clk) disable iff (slow_rst)
    !run_s |=> !wdt_reset_o); // R6

  AST_LOCKED_RELOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(unlocked) |-> $stable(rl_sh)); // R4

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy[1]) |-> $past(bus_we_i && bus_addr_i == 2'd2)); // R9

  AST_FREEZE_HOLDS_COUNT: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (frz_s && !ev[2]) |=> $stable(cnt)); // R10

  AST_COUNT_STEP: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (run_s && !frz_s && !ev[2] && cnt != '0) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1))); // R2
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .NCH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
  .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .slow_clk_req_o(slow_clk_req_o),
  .wdt_reset_o(wdt_reset_o), .unlocked(unlocked), .rl_sh(rl_sh), .busy(busy),
  .ev(ev), .run_s(run_s), .frz_s(frz_s), .cnt(cnt)
);

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;
  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst, slow_rst, hw_start, freeze, we;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        clk_req, wdt_rst;

  int n_chk = 0;
  int n_fail = 0;
  int slow_cyc = 0;
  int pulse_cnt = 0;
  int first_pulse = -1;
  bit armed = 0;

  kwdt_top dut (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .hw_start_i(hw_start), .dbg_freeze_i(freeze), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .slow_clk_req_o(clk_req), .wdt_reset_o(wdt_rst)
  );

  always #5 clk = ~clk;
  always #17 slow_clk = ~slow_clk;

  always @(posedge slow_clk) slow_cyc++;
  always @(negedge slow_clk) begin
    if (wdt_rst) begin
      pulse_cnt++;
      if (armed && first_pulse < 0) first_pulse = slow_cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge slow_clk);
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(2'd3, s);
      if (s[1:0] == 2'b00) break;
    end
  endtask

  task automatic do_reset(input logic strap);
    hw_start = strap; rst = 1'b1; slow_rst = 1'b1;
    repeat (4) @(posedge slow_clk);
    @(negedge clk); rst = 1'b0; slow_rst = 1'b0;
  endtask

  // refresh, then time the next pulse from a second refresh
  task automatic measure(input int exp, input string req);
    int mark;
    wr(2'd0, 16'hAAAA);
    wait_slow(10);
    first_pulse = -1; armed = 1; mark = slow_cyc;
    wr(2'd0, 16'hAAAA);
    while (first_pulse < 0 && slow_cyc < mark + exp + 60) @(posedge slow_clk);
    armed = 0;
    chk_win(req, (first_pulse < 0) ? -1 : first_pulse - mark, exp, exp + 8);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd3, d); chk(d == 16'h0, "R9 status at reset", d, 0);
    rd(2'd1, d); chk(d == 16'h0, "R4 prescaler reset", d, 0);
    rd(2'd2, d); chk(d == 16'h0FFF, "R4 reload reset", d, 16'h0FFF);
    rd(2'd0, d); chk(d == 16'h0, "R4 key reads zero", d, 0);
    chk(clk_req == 1'b0, "R6 no clock request before start", clk_req, 0);
    chk(wdt_rst == 1'b0, "R6 no reset pulse at reset", wdt_rst, 0);
  endtask

  task automatic t_locked();
    logic [15:0] d;
    wr(2'd2, 16'h000F);
    wr(2'd1, 16'h0003);
    wait_idle();
    rd(2'd2, d); chk(d == 16'h0FFF, "R4 locked reload write ignored", d, 16'h0FFF);
    rd(2'd1, d); chk(d == 16'h0, "R4 locked prescaler write ignored", d, 0);
  endtask

  task automatic t_unlock_busy();
    logic [15:0] d;
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'h000F);
    wr(2'd2, 16'h00AA);
    rd(2'd3, d); chk(d == 16'h0002, "R9 reload busy after write", d, 2);
    wait_idle();
    rd(2'd3, d); chk(d == 16'h0, "R9 busy clears after ack", d, 0);
    rd(2'd2, d); chk(d == 16'h000F, "R9 write while busy ignored", d, 16'h000F);
  endtask

  task automatic t_relock();
    logic [15:0] d;
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0005);
    wait_idle();
    rd(2'd1, d); chk(d == 16'h0, "R5 other key relocks", d, 0);
  endtask

  task automatic t_not_started();
    int p0;
    p0 = pulse_cnt;
    wr(2'd0, 16'hAAAA);
    wait_slow(600);
    chk(pulse_cnt == p0, "R6 no pulse before start", pulse_cnt - p0, 0);
    chk(clk_req == 1'b0, "R6 clock request still low", clk_req, 0);
  endtask

  task automatic t_start();
    wr(2'd0, 16'hCCCC);
    @(negedge clk);
    chk(clk_req == 1'b1, "R6 start raises clock request", clk_req, 1);
    measure(64, "R2 timeout reload 15 div 4");
  endtask

  task automatic t_keepalive();
    int p0;
    p0 = pulse_cnt;
    for (int i = 0; i < 10; i++) begin
      wr(2'd0, 16'hAAAA);
      wait_slow(30);
    end
    chk(pulse_cnt == p0, "R2 refresh prevents reset", pulse_cnt - p0, 0);
    p0 = pulse_cnt;
    wait_slow(640);
    chk_win("R3 periodic pulses without refresh", pulse_cnt - p0, 9, 11);
  endtask

  task automatic t_presc();
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0002);
    wait_idle();
    measure(256, "R8 code 2 divides by 16");
    wr(2'd1, 16'h0007);
    wr(2'd2, 16'h0000);
    wait_idle();
    measure(256, "R8 code 7 divides by 256");
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0003);
    wait_idle();
    measure(32, "R8 code 1 divides by 8");
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h000F);
    wait_idle();
    measure(64, "R8 code 0 divides by 4");
  endtask

  task automatic t_freeze();
    int mark;
    wr(2'd0, 16'hAAAA);
    wait_slow(10);
    first_pulse = -1; armed = 1; mark = slow_cyc;
    wr(2'd0, 16'hAAAA);
    wait_slow(5);
    freeze = 1'b1;
    wait_slow(200);
    freeze = 1'b0;
    while (first_pulse < 0 && slow_cyc < mark + 400) @(posedge slow_clk);
    armed = 0;
    chk_win("R10 freeze delays timeout", (first_pulse < 0) ? -1 : first_pulse - mark, 262, 272);
  endtask

  task automatic t_no_stop();
    int p0;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'hCCCC);
    @(negedge clk);
    chk(clk_req == 1'b1, "R6 clock request cannot be cleared", clk_req, 1);
    p0 = pulse_cnt;
    wait_slow(200);
    chk(pulse_cnt - p0 >= 2, "R6 counting cannot be stopped", pulse_cnt - p0, 3);
  endtask

  task automatic t_hwstrap();
    int mark;
    do_reset(1'b1);
    first_pulse = -1; armed = 1; mark = slow_cyc;
    @(negedge clk);
    chk(clk_req == 1'b1, "R7 strap starts watchdog", clk_req, 1);
    while (first_pulse < 0 && slow_cyc < mark + 16384 + 100) @(posedge slow_clk);
    armed = 0;
    chk_win("R1 first timeout from 0xFFF", (first_pulse < 0) ? -1 : first_pulse - mark,
            16384, 16392);
  endtask

  initial begin
    we = 1'b0; addr = 2'd0; wdata = 16'h0; freeze = 1'b0;
    do_reset(1'b0);
    t_reset();
    t_locked();
    t_unlock_busy();
    t_relock();
    t_not_started();
    t_start();
    t_keepalive();
    t_presc();
    t_freeze();
    t_no_stop();
    t_hwstrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule